// File: doc/BRIEF.md
# MII to RMII Interface Adapter

This block joins a MAC that speaks the four-bit media independent interface to a PHY wired with the reduced pin-count interface. It runs entirely on the 50 MHz reference clock. In conversion mode each transmit nibble is split into two 2-bit symbols. The low pair goes out first, then the high pair, together with the transmit enable. On receive, pairs of received symbols are rebuilt into nibbles. The single combined carrier-sense/data-valid input is split back into a carrier sense output and a data valid output for the MAC.

A mode input selects between conversion and a plain pass-through that wires the full four-bit interface straight through in both directions. A speed input selects 100 Mb/s, with one symbol per reference clock, or 10 Mb/s, where each symbol lasts a fixed number of reference clocks. The MAC is paced by two one-cycle strobes. One marks when a transmit nibble is taken. The other marks when a received nibble is presented.

Top module: `mii_rmii_bridge`

## Requirements
- R1: With `rmii_sel` low, all PHY-side inputs appear unchanged on the MAC-side outputs and all MAC-side inputs appear unchanged on the PHY-side outputs in the same cycle. Carrier sense comes from `phy_crs` and data valid from `phy_rx_dv`. Both strobes are high.
- R2: With `rmii_sel` high, the nibble on `mac_txd` is captured in the cycle `mac_tx_stb` is high. Bits [1:0] then appear on `phy_txd[1:0]` for one symbol period, then bits [3:2] for the next. `phy_tx_en` carries the captured `mac_tx_en` for both symbols. `phy_txd[3:2]` is zero.
- R3: With `speed_100` high, one symbol is sent per clock, so `mac_tx_stb` is high on every other cycle while converting.
- R4: With `speed_100` low, each transmit symbol is held for SLOW_DIV (10) clocks. The receive side samples one symbol per SLOW_DIV clocks.
- R5: After the combined input `phy_rx_dv` has been sampled low, the first sampled symbol equal to binary 01 with `phy_rx_dv` high is taken as the low half of the first nibble. Symbols sampled before it, including 00 symbols while the input is high, are discarded.
- R6: Each rebuilt nibble is {second symbol, first symbol} on `mac_rxd`. It is marked by a one-cycle `mac_rx_stb` with `mac_rx_dv` high, and a transmit-to-receive loop returns every transmitted nibble unchanged in both modes and at both speeds.
- R7: A nibble whose two combined-input samples are both high raises `mac_crs`. Once a nibble has a low sample, `mac_crs` stays low for the rest of the frame while `mac_rx_dv` stays high. A nibble with both samples low ends the frame, dropping `mac_rx_dv` and `mac_crs`.
- R8: If `phy_rx_er` is high during either symbol of a nibble, `mac_rx_er` is high for that nibble only.
- R9: With `rmii_sel` high, `mac_col` stays low whatever `phy_col` does, and `phy_tx_er` stays low whatever `mac_tx_er` does.
- R10: During reset in conversion mode, `phy_tx_en`, `mac_rx_dv`, `mac_crs`, `mac_rx_er`, `mac_col` and `mac_rx_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rmii_sel | input | 1 | 1: convert to reduced interface, 0: pass-through |
| speed_100 | input | 1 | 1: 100 Mb/s, 0: 10 Mb/s |
| mac_txd | input | 4 | Transmit nibble from MAC |
| mac_tx_en | input | 1 | Transmit enable from MAC |
| mac_tx_er | input | 1 | Transmit error from MAC (pass-through only) |
| mac_tx_stb | output | 1 | Transmit nibble taken this cycle |
| mac_rxd | output | 4 | Receive nibble to MAC |
| mac_rx_dv | output | 1 | Receive data valid to MAC |
| mac_crs | output | 1 | Carrier sense to MAC |
| mac_rx_er | output | 1 | Receive error to MAC |
| mac_col | output | 1 | Collision to MAC |
| mac_rx_stb | output | 1 | New receive nibble this cycle |
| phy_txd | output | 4 | Transmit data to PHY (bits [1:0] in conversion mode) |
| phy_tx_en | output | 1 | Transmit enable to PHY |
| phy_tx_er | output | 1 | Transmit error to PHY |
| phy_rxd | input | 4 | Receive data from PHY (bits [1:0] in conversion mode) |
| phy_rx_dv | input | 1 | Data valid, or combined carrier/valid in conversion mode |
| phy_crs | input | 1 | Carrier sense from PHY (pass-through only) |
| phy_col | input | 1 | Collision from PHY (pass-through only) |
| phy_rx_er | input | 1 | Receive error from PHY |

## Verification
The bench builds the block with its defaults: four-bit nibbles, two-bit symbols and a slow divider of 10. At these values the 10 Mb/s symbol hold and sampling spacing can be counted clock by clock against the true rate ratio. Frame-level loop tests in both modes at both speeds stay short enough to run many of them. Driving the receive pins directly at 100 Mb/s puts one symbol on each clock. That makes unaligned preambles, toggling of the combined input at frame end and single-symbol receive errors easy to place on exact symbol positions.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  localparam int NIB_BITS = 4;
  localparam int DIB_BITS = 2;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_ARMED = 2'd1,
    RX_FRAME = 2'd2
  } rx_state_e;
endpackage

// File: rtl/mrb_rate_gen.sv
module mrb_rate_gen #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic dibit_en
);
  localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOW_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign dibit_en = fast | (cnt_q == LAST);

  // R4: at the slow rate a symbol enable is never followed by another one
  p_slow_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast && dibit_en) |=> (fast || !dibit_en));
endmodule

// File: rtl/mrb_tx_split.sv
module mrb_tx_split
  import mrb_pkg::*;
#(
  parameter int NIB_W = NIB_BITS,
  parameter int DIB_W = DIB_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             fast,
  input  logic             dibit_en,
  input  logic [NIB_W-1:0] nib_in,
  input  logic             nib_en,
  output logic             nib_stb,
  output logic [DIB_W-1:0] dib_out,
  output logic             dib_en
);
  logic             phase_q, phase_d;
  logic [DIB_W-1:0] hi_q, hi_d;
  logic [DIB_W-1:0] dib_q, dib_d;
  logic             en_q, en_d;

  assign nib_stb = active & dibit_en & ~phase_q;

  always_comb begin
    phase_d = phase_q;
    hi_d    = hi_q;
    dib_d   = dib_q;
    en_d    = en_q;
    if (!active) begin
      phase_d = 1'b0;
      dib_d   = '0;
      en_d    = 1'b0;
    end else if (dibit_en) begin
      if (!phase_q) begin
        dib_d   = nib_in[DIB_W-1:0];
        hi_d    = nib_in[NIB_W-1:DIB_W];
        en_d    = nib_en;
        phase_d = 1'b1;
      end else begin
        dib_d   = hi_q;
        phase_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
      dib_q   <= '0;
      en_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      hi_q    <= hi_d;
      dib_q   <= dib_d;
      en_q    <= en_d;
    end
  end

  assign dib_out = dib_q;
  assign dib_en  = en_q;

  // R2: the symbol after a capture is the low half with the captured enable
  p_lo_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nib_stb |=> (dib_out == $past(nib_in[DIB_W-1:0]) && dib_en == $past(nib_en)));

  // R2: at full rate the high half follows one clock later
  p_hi_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_stb && fast) ##1 fast |=> (!active || dib_out == $past(nib_in[NIB_W-1:DIB_W], 2)));

  // R3: at full rate captures never occur on back-to-back clocks
  p_stb_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_stb && fast) |=> !nib_stb);
endmodule

// File: rtl/mrb_rx_merge.sv
module mrb_rx_merge
  import mrb_pkg::*;
#(
  parameter int NIB_W = NIB_BITS,
  parameter int DIB_W = DIB_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             dibit_en,
  input  logic             crs_dv,
  input  logic [DIB_W-1:0] dib_in,
  input  logic             rx_er_in,
  output logic [NIB_W-1:0] nib_out,
  output logic             nib_stb,
  output logic             dv,
  output logic             crs,
  output logic             er
);
  localparam logic [DIB_W-1:0] PREAMBLE_SYM = DIB_W'(1);

  rx_state_e        state_q, state_d;
  logic             phase_q, phase_d;
  logic [DIB_W-1:0] lo_q, lo_d;
  logic             c0_q, c0_d;
  logic             er0_q, er0_d;
  logic             lost_q, lost_d;
  logic [NIB_W-1:0] nib_q, nib_d;
  logic             stb_q, stb_d;
  logic             dv_q, dv_d;
  logic             crs_q, crs_d;
  logic             er_q, er_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    lo_d    = lo_q;
    c0_d    = c0_q;
    er0_d   = er0_q;
    lost_d  = lost_q;
    nib_d   = nib_q;
    stb_d   = 1'b0;
    dv_d    = dv_q;
    crs_d   = crs_q;
    er_d    = er_q;
    if (!active) begin
      state_d = RX_IDLE;
      phase_d = 1'b0;
      lost_d  = 1'b0;
      dv_d    = 1'b0;
      crs_d   = 1'b0;
      er_d    = 1'b0;
    end else if (dibit_en) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!crs_dv) state_d = RX_ARMED;
        end
        RX_ARMED: begin
          if (crs_dv && dib_in == PREAMBLE_SYM) begin
            state_d = RX_FRAME;
            lo_d    = dib_in;
            c0_d    = 1'b1;
            er0_d   = rx_er_in;
            lost_d  = 1'b0;
            phase_d = 1'b1;
          end
        end
        RX_FRAME: begin
          if (!phase_q) begin
            lo_d    = dib_in;
            c0_d    = crs_dv;
            er0_d   = rx_er_in;
            phase_d = 1'b1;
          end else begin
            phase_d = 1'b0;
            if (!c0_q && !crs_dv) begin
              state_d = RX_ARMED;
              dv_d    = 1'b0;
              crs_d   = 1'b0;
              er_d    = 1'b0;
            end else begin
              nib_d = {dib_in, lo_q};
              stb_d = 1'b1;
              dv_d  = 1'b1;
              er_d  = er0_q | rx_er_in;
              if (c0_q && crs_dv && !lost_q) begin
                crs_d = 1'b1;
              end else begin
                crs_d  = 1'b0;
                lost_d = 1'b1;
              end
            end
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      phase_q <= 1'b0;
      lo_q    <= '0;
      c0_q    <= 1'b0;
      er0_q   <= 1'b0;
      lost_q  <= 1'b0;
      nib_q   <= '0;
      stb_q   <= 1'b0;
      dv_q    <= 1'b0;
      crs_q   <= 1'b0;
      er_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      lo_q    <= lo_d;
      c0_q    <= c0_d;
      er0_q   <= er0_d;
      lost_q  <= lost_d;
      nib_q   <= nib_d;
      stb_q   <= stb_d;
      dv_q    <= dv_d;
      crs_q   <= crs_d;
      er_q    <= er_d;
    end
  end

  assign nib_out = nib_q;
  assign nib_stb = stb_q;
  assign dv      = dv_q;
  assign crs     = crs_q;
  assign er      = er_q;

  // R6: a nibble marker always comes with data valid
  p_stb_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nib_stb |-> dv);

  // R6: every nibble takes at least two symbols
  p_stb_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nib_stb |=> !nib_stb);

  // R7: carrier sense is never raised without data valid
  p_crs_in_dv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crs |-> dv);

  // R7: once carrier is dropped inside a frame it is not raised again in it
  p_crs_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dv) && !$past(crs) && dv) |-> !crs);

  // R8: receive error is only reported on a valid nibble
  p_er_in_dv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    er |-> dv);
endmodule

// File: rtl/mii_rmii_bridge.sv
module mii_rmii_bridge
  import mrb_pkg::*;
#(
  parameter int NIB_W    = NIB_BITS,
  parameter int DIB_W    = DIB_BITS,
  parameter int SLOW_DIV = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rmii_sel,
  input  logic             speed_100,
  input  logic [NIB_W-1:0] mac_txd,
  input  logic             mac_tx_en,
  input  logic             mac_tx_er,
  output logic             mac_tx_stb,
  output logic [NIB_W-1:0] mac_rxd,
  output logic             mac_rx_dv,
  output logic             mac_crs,
  output logic             mac_rx_er,
  output logic             mac_col,
  output logic             mac_rx_stb,
  output logic [NIB_W-1:0] phy_txd,
  output logic             phy_tx_en,
  output logic             phy_tx_er,
  input  logic [NIB_W-1:0] phy_rxd,
  input  logic             phy_rx_dv,
  input  logic             phy_crs,
  input  logic             phy_col,
  input  logic             phy_rx_er
);
  localparam int PAD_W = NIB_W - DIB_W;

  logic             dibit_en;
  logic             tx_stb;
  logic [DIB_W-1:0] tx_dib;
  logic             tx_dib_en;
  logic [NIB_W-1:0] rx_nib;
  logic             rx_stb, rx_dv, rx_crs, rx_er;

  mrb_rate_gen #(.SLOW_DIV(SLOW_DIV)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .fast     (speed_100),
    .dibit_en (dibit_en)
  );

  mrb_tx_split #(.NIB_W(NIB_W), .DIB_W(DIB_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (rmii_sel),
    .fast     (speed_100),
    .dibit_en (dibit_en),
    .nib_in   (mac_txd),
    .nib_en   (mac_tx_en),
    .nib_stb  (tx_stb),
    .dib_out  (tx_dib),
    .dib_en   (tx_dib_en)
  );

  mrb_rx_merge #(.NIB_W(NIB_W), .DIB_W(DIB_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (rmii_sel),
    .dibit_en (dibit_en),
    .crs_dv   (phy_rx_dv),
    .dib_in   (phy_rxd[DIB_W-1:0]),
    .rx_er_in (phy_rx_er),
    .nib_out  (rx_nib),
    .nib_stb  (rx_stb),
    .dv       (rx_dv),
    .crs      (rx_crs),
    .er       (rx_er)
  );

  always_comb begin
    if (rmii_sel) begin
      phy_txd    = {{PAD_W{1'b0}}, tx_dib};
      phy_tx_en  = tx_dib_en;
      phy_tx_er  = 1'b0;
      mac_tx_stb = tx_stb;
      mac_rxd    = rx_nib;
      mac_rx_dv  = rx_dv;
      mac_crs    = rx_crs;
      mac_rx_er  = rx_er;
      mac_col    = 1'b0;
      mac_rx_stb = rx_stb;
    end else begin
      phy_txd    = mac_txd;
      phy_tx_en  = mac_tx_en;
      phy_tx_er  = mac_tx_er;
      mac_tx_stb = 1'b1;
      mac_rxd    = phy_rxd;
      mac_rx_dv  = phy_rx_dv;
      mac_crs    = phy_crs;
      mac_rx_er  = phy_rx_er;
      mac_col    = phy_col;
      mac_rx_stb = 1'b1;
    end
  end
endmodule

// File: tb/mii_rmii_bridge_tb.sv
module mii_rmii_bridge_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rmii_sel, speed_100, lb;
  logic [3:0] mac_txd;
  logic       mac_tx_en, mac_tx_er;
  logic       mac_tx_stb;
  logic [3:0] mac_rxd;
  logic       mac_rx_dv, mac_crs, mac_rx_er, mac_col, mac_rx_stb;
  logic [3:0] phy_txd;
  logic       phy_tx_en, phy_tx_er;
  logic [3:0] phy_rxd;
  logic       phy_rx_dv, phy_crs, phy_col, phy_rx_er;
  logic [3:0] d_rxd;
  logic       d_crsdv, d_crs, d_rxer, d_col;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0] rec_nib [256];
  logic       rec_crs [256];
  logic       rec_er  [256];
  int         rec_n = 0;

  always #5 clk = ~clk;

  assign phy_rxd   = lb ? phy_txd   : d_rxd;
  assign phy_rx_dv = lb ? phy_tx_en : d_crsdv;
  assign phy_crs   = lb ? phy_tx_en : d_crs;
  assign phy_rx_er = lb ? phy_tx_er : d_rxer;
  assign phy_col   = d_col;

  mii_rmii_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .rmii_sel(rmii_sel), .speed_100(speed_100),
    .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .mac_tx_er(mac_tx_er),
    .mac_tx_stb(mac_tx_stb), .mac_rxd(mac_rxd), .mac_rx_dv(mac_rx_dv),
    .mac_crs(mac_crs), .mac_rx_er(mac_rx_er), .mac_col(mac_col),
    .mac_rx_stb(mac_rx_stb), .phy_txd(phy_txd), .phy_tx_en(phy_tx_en),
    .phy_tx_er(phy_tx_er), .phy_rxd(phy_rxd), .phy_rx_dv(phy_rx_dv),
    .phy_crs(phy_crs), .phy_col(phy_col), .phy_rx_er(phy_rx_er)
  );

  always @(negedge clk) begin
    if (rst_n && mac_rx_stb && mac_rx_dv && rec_n < 256) begin
      rec_nib[rec_n] <= mac_rxd;
      rec_crs[rec_n] <= mac_crs;
      rec_er[rec_n]  <= mac_rx_er;
      rec_n <= rec_n + 1;
    end
  end

  // frame table: {rmii, speed_100, payload length, seed}
  localparam int NFR = 6;
  localparam logic [13:0] FRAMES [NFR] = '{
    {1'b1, 1'b1, 4'd9,  8'h3C},
    {1'b1, 1'b0, 4'd5,  8'hA1},
    {1'b0, 1'b1, 4'd7,  8'h55},
    {1'b0, 1'b0, 4'd4,  8'h0F},
    {1'b1, 1'b1, 4'd15, 8'hF2},
    {1'b1, 1'b0, 4'd3,  8'h7E}
  };

  function automatic logic [3:0] nib_at(input logic [7:0] seed, input int i);
    logic [7:0] t;
    if (i < 2)  return 4'h5;
    if (i == 2) return 4'hD;
    t = seed + 8'(i * 7);
    return t[3:0];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all stimulus tasks start and end one time unit after a rising edge
  task automatic send_nib(input logic [3:0] n, input logic en);
    mac_txd   = n;
    mac_tx_en = en;
    do @(negedge clk); while (!mac_tx_stb);
    @(posedge clk); #1;
  endtask

  task automatic drive_dib(input logic c, input logic [1:0] d, input logic e);
    d_crsdv = c;
    d_rxd   = {2'b00, d};
    d_rxer  = e;
    @(posedge clk); #1;
  endtask

  task automatic run_frame(input logic [13:0] f);
    int base, total;
    rmii_sel  = f[13];
    speed_100 = f[12];
    lb        = 1'b1;
    repeat (3) send_nib(4'h0, 1'b0);
    base  = rec_n;
    total = int'(f[11:8]) + 3;
    for (int i = 0; i < total; i++) send_nib(nib_at(f[7:0], i), 1'b1);
    repeat (3) send_nib(4'h0, 1'b0);
    repeat (4) @(posedge clk);
    #1;
    chk("R6 loop nibble count", rec_n - base, total);
    for (int i = 0; i < total; i++) begin
      chk("R6 loop nibble value", rec_nib[base + i], nib_at(f[7:0], i));
      chk("R6 loop carrier", rec_crs[base + i], 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base, n;
    rst_n = 1'b0; rmii_sel = 1'b1; speed_100 = 1'b1; lb = 1'b0;
    mac_txd = 4'h0; mac_tx_en = 1'b0; mac_tx_er = 1'b0;
    d_rxd = 4'h0; d_crsdv = 1'b0; d_crs = 1'b0; d_rxer = 1'b0; d_col = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 phy_tx_en", phy_tx_en, 0);
    chk("R10 mac_rx_dv", mac_rx_dv, 0);
    chk("R10 mac_crs", mac_crs, 0);
    chk("R10 mac_rx_er", mac_rx_er, 0);
    chk("R10 mac_col", mac_col, 0);
    chk("R10 mac_rx_stb", mac_rx_stb, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R9 collision and transmit error unused in conversion mode
    d_col = 1'b1; mac_tx_er = 1'b1;
    @(negedge clk);
    chk("R9 mac_col held low", mac_col, 0);
    chk("R9 phy_tx_er held low", phy_tx_er, 0);
    // R1 pass-through
    @(posedge clk); #1;
    rmii_sel = 1'b0; d_rxd = 4'hA; d_crs = 1'b1; d_crsdv = 1'b0;
    mac_txd = 4'h6; mac_tx_en = 1'b1;
    @(negedge clk);
    chk("R1 mac_col", mac_col, 1);
    chk("R1 phy_tx_er", phy_tx_er, 1);
    chk("R1 mac_rxd", mac_rxd, 4'hA);
    chk("R1 mac_crs", mac_crs, 1);
    chk("R1 mac_rx_dv", mac_rx_dv, 0);
    chk("R1 phy_txd", phy_txd, 4'h6);
    chk("R1 phy_tx_en", phy_tx_en, 1);
    chk("R1 strobes", {mac_tx_stb, mac_rx_stb}, 2'b11);
    @(posedge clk); #1;
    rmii_sel = 1'b1; d_col = 1'b0; mac_tx_er = 1'b0; d_crs = 1'b0;
    d_rxd = 4'h0; mac_tx_en = 1'b0; mac_txd = 4'h0;
    repeat (4) @(posedge clk);
    #1;

    // R2 / R3 symbol order at full rate
    mac_txd = 4'hB; mac_tx_en = 1'b1;
    do @(negedge clk); while (!mac_tx_stb);
    @(negedge clk);
    chk("R2 low symbol first", phy_txd, 4'h3);
    chk("R2 enable follows", phy_tx_en, 1);
    chk("R3 no capture next clock", mac_tx_stb, 0);
    @(negedge clk);
    chk("R2 high symbol second", phy_txd, 4'h2);
    chk("R2 enable held", phy_tx_en, 1);
    chk("R3 capture every other clock", mac_tx_stb, 1);
    @(posedge clk); #1;
    mac_tx_en = 1'b0; mac_txd = 4'h0;
    repeat (4) @(posedge clk);
    #1;

    // R4 symbol hold at 10 Mb/s
    speed_100 = 1'b0;
    mac_txd = 4'h6; mac_tx_en = 1'b1;
    do @(negedge clk); while (!mac_tx_stb);
    @(negedge clk);
    chk("R4 low symbol", phy_txd, 4'h2);
    n = 1;
    while (phy_txd == 4'h2 && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk("R4 hold cycles", n - 1, 10);
    chk("R4 high symbol", phy_txd, 4'h1);
    @(posedge clk); #1;
    mac_tx_en = 1'b0; mac_txd = 4'h0;
    repeat (40) @(posedge clk);
    #1;
    speed_100 = 1'b1;

    // R7 combined input toggling at frame end
    base = rec_n;
    drive_dib(1'b0, 2'b00, 1'b0); drive_dib(1'b0, 2'b00, 1'b0);
    drive_dib(1'b1, 2'b01, 1'b0); drive_dib(1'b1, 2'b01, 1'b0);
    drive_dib(1'b1, 2'b10, 1'b0); drive_dib(1'b1, 2'b10, 1'b0);
    drive_dib(1'b0, 2'b11, 1'b0); drive_dib(1'b1, 2'b11, 1'b0);
    drive_dib(1'b0, 2'b00, 1'b0); drive_dib(1'b1, 2'b00, 1'b0);
    drive_dib(1'b0, 2'b00, 1'b0); drive_dib(1'b0, 2'b00, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk("R7 nibble count", rec_n - base, 4);
    chk("R7 nibbles", {rec_nib[base], rec_nib[base+1], rec_nib[base+2], rec_nib[base+3]}, 16'h5AF0);
    chk("R7 carrier per nibble", {rec_crs[base], rec_crs[base+1], rec_crs[base+2], rec_crs[base+3]}, 4'b1100);
    chk("R7 valid dropped at end", mac_rx_dv, 0);
    chk("R7 carrier dropped at end", mac_crs, 0);

    // R5 alignment on the preamble symbol
    base = rec_n;
    drive_dib(1'b0, 2'b00, 1'b0); drive_dib(1'b0, 2'b00, 1'b0);
    drive_dib(1'b1, 2'b00, 1'b0); drive_dib(1'b1, 2'b00, 1'b0);
    drive_dib(1'b1, 2'b00, 1'b0);
    drive_dib(1'b1, 2'b01, 1'b0); drive_dib(1'b1, 2'b01, 1'b0);
    drive_dib(1'b1, 2'b01, 1'b0); drive_dib(1'b1, 2'b01, 1'b0);
    drive_dib(1'b1, 2'b01, 1'b0); drive_dib(1'b1, 2'b11, 1'b0);
    drive_dib(1'b1, 2'b01, 1'b0); drive_dib(1'b1, 2'b10, 1'b0);
    drive_dib(1'b0, 2'b00, 1'b0); drive_dib(1'b0, 2'b00, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk("R5 nibble count", rec_n - base, 4);
    chk("R5 aligned nibbles", {rec_nib[base], rec_nib[base+1], rec_nib[base+2], rec_nib[base+3]}, 16'h55D9);
    chk("R5 carrier restored", {rec_crs[base], rec_crs[base+1], rec_crs[base+2], rec_crs[base+3]}, 4'b1111);

    // R8 receive error spans its nibble only
    base = rec_n;
    drive_dib(1'b1, 2'b01, 1'b0); drive_dib(1'b1, 2'b01, 1'b1);
    drive_dib(1'b1, 2'b01, 1'b0); drive_dib(1'b1, 2'b01, 1'b0);
    drive_dib(1'b1, 2'b01, 1'b1); drive_dib(1'b1, 2'b11, 1'b0);
    drive_dib(1'b0, 2'b00, 1'b0); drive_dib(1'b0, 2'b00, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk("R8 nibble count", rec_n - base, 3);
    chk("R8 error flags", {rec_er[base], rec_er[base+1], rec_er[base+2]}, 3'b101);
    chk("R8 error cleared at end", mac_rx_er, 0);

    // R6 loop frames in both modes and both speeds
    for (int k = 0; k < NFR; k++) run_frame(FRAMES[k]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule